// File: doc/BRIEF.md
# Triggered Waveform Event Recorder

This block watches one ADC channel's stream of 8-bit samples and always keeps the most recent samples in a circular history. When a trigger arrives it turns the moment into an event record and writes it into one bank of a two-bank event memory. A record is a 16-byte header, then a programmable number of samples taken after the trigger, then the 128 samples held from before it. Samples are packed in pairs into 16-bit memory words.

Records are laid end to end in the active bank. A readout agent asks for a bank swap when it wants to drain the bank it has been filling. The swap is taken at the next record boundary, and later records go to the start of the other bank, so capture never stops. A record that would not fit in what is left of the active bank is dropped whole, and a sticky flag reports the loss. A free-running 48-bit cycle counter stamps each record, and a 16-bit event number counts the records that are written.

Top module: `wave_event_rec`

## Requirements
- R1: While reset is held and in the first cycle after it ends, `mem_wr_en`, `busy`, `overflow` and `active_bank` are all 0.
- R2: An accepted record covers 8 + floor(P/2) + 64 consecutive word addresses of the active bank, where P is `post_len`. The 8 header words come first, at the record base. The post-trigger words start at base+8 and the pre-trigger words follow them. The first record after reset or after a swap has base 0. Each later record's base is the previous base plus the previous record's length. No other writes occur.
- R3: Header bytes are numbered 0 to 15, and word k holds byte 2k+1 in bits 15:8 and byte 2k in bits 7:0. Byte 0 is `CHAN_ID`. Bytes 1-2 hold P and bytes 3-4 hold the pre length 128. Bytes 5-6 hold the event number. Bytes 7-12 hold the timestamp, bits 47:0. Bytes 13-14 hold `trig_tag` and byte 15 is 0. Every multi-byte field is stored high byte first.
- R4: Post-trigger word i holds post sample 2i+1 in bits 15:8 and sample 2i in bits 7:0. The post samples are the valid samples starting with the one in the accepted trigger cycle, if it is valid.
- R5: The pre-trigger block holds the 128 most recent valid samples taken while idle before the trigger cycle, oldest first, packed as in R4. Slots not yet filled since reset read 0. Samples that arrive while `busy` is high, or in an accepted trigger cycle, never enter the history.
- R6: Bit 0 of `post_len` selects no data word, so an odd final sample is not stored. The header still carries the full value. P = 0 gives a record with no post-trigger words.
- R7: The event number in a header is the count of records completed since reset, starting at 0.
- R8: The timestamp in a header equals the number of clock cycles between the end of reset and the trigger cycle.
- R9: A trigger while `busy` is high is ignored. It writes nothing and does not change the event number.
- R10: A pulse on `swap_req` toggles `active_bank` at the end of the first idle cycle at or after the pulse. A pulse in an idle trigger cycle takes effect before that trigger is placed. Writes always target `active_bank`.
- R11: A trigger whose record would pass the end of the bank (base + length > 1024 words by default) writes nothing. It sets `overflow`, which stays set until reset, and it leaves the event number unchanged. That cycle's sample enters the history. A record that ends exactly at the bank end is accepted.
- R12: `busy` rises only in the cycle after an accepted trigger and falls in the cycle that presents the last header write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 8 | ADC sample |
| trig | input | 1 | Trigger request |
| trig_tag | input | 16 | Trigger information copied into the header |
| post_len | input | 16 | Post-trigger length in samples, sampled at trigger |
| swap_req | input | 1 | Bank swap request pulse |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_bank | output | 1 | Bank of this write |
| mem_wr_addr | output | ADDR_W | Word address inside the bank |
| mem_wr_data | output | 16 | Word written |
| active_bank | output | 1 | Bank that receives records |
| overflow | output | 1 | Sticky record-dropped flag |
| busy | output | 1 | A record is being written |

## Verification
`busy` is due one cycle after an accepted trigger. A post-trigger word is written one cycle after the sample that completes its pair. The 64 pre-trigger words and then the 8 header words follow, one per cycle, and the last header write is presented in the same cycle `busy` falls. The bench drives inputs and samples outputs on the falling edge. It waits for `busy` to drop plus one further falling edge before it compares a record word by word. A swap is checked on that same edge, or one edge after an idle pulse. Overflow and the absence of writes are checked three edges after a dropped trigger.

// File: rtl/wave_rec_pkg.sv
package wave_rec_pkg;
    localparam int SMP_W     = 8;
    localparam int WORD_W    = 16;
    localparam int HDR_WORDS = 8;
    localparam int TS_W      = 48;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POST = 2'd1,
        ST_PRE  = 2'd2,
        ST_HDR  = 2'd3
    } rec_state_e;

    // Header word k packs byte 2k (low) and byte 2k+1 (high); fields high byte first.
    function automatic logic [WORD_W-1:0] hdr_word(
        input logic [2:0]       idx,
        input logic [7:0]       chan,
        input logic [15:0]      plen,
        input logic [15:0]      prelen,
        input logic [15:0]      evn,
        input logic [TS_W-1:0]  ts,
        input logic [15:0]      tag
    );
        logic [WORD_W-1:0] w;
        case (idx)
            3'd0:    w = {plen[15:8],   chan};
            3'd1:    w = {prelen[15:8], plen[7:0]};
            3'd2:    w = {evn[15:8],    prelen[7:0]};
            3'd3:    w = {ts[47:40],    evn[7:0]};
            3'd4:    w = {ts[31:24],    ts[39:32]};
            3'd5:    w = {ts[15:8],     ts[23:16]};
            3'd6:    w = {tag[15:8],    ts[7:0]};
            default: w = {8'h00,        tag[7:0]};
        endcase
        return w;
    endfunction
endpackage

// File: rtl/wave_rec_history.sv
module wave_rec_history #(
    parameter int DEPTH  = 128,
    parameter int SMP_W  = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PAIR_W = IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SMP_W-1:0]  wdat,
    input  logic [PAIR_W-1:0] pair_idx,
    output logic [SMP_W-1:0]  rd_lo,
    output logic [SMP_W-1:0]  rd_hi
);
    logic [SMP_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0] wptr_q;
    logic [IDX_W-1:0] idx0;
    logic [IDX_W-1:0] idx1;

    // The slot at the write pointer is the oldest entry.
    always_comb begin
        idx0  = wptr_q + {pair_idx, 1'b0};
        idx1  = idx0 + 1'b1;
        rd_lo = mem_q[idx0];
        rd_hi = mem_q[idx1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[wptr_q] <= wdat;
            wptr_q        <= wptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/wave_rec_tstamp.sv
module wave_rec_tstamp #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] ts
);
    logic [W-1:0] ts_q;

    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_q + 1'b1;
    end

    assign ts = ts_q;
endmodule

// File: rtl/wave_event_rec.sv
module wave_event_rec
    import wave_rec_pkg::*;
#(
    parameter logic [7:0] CHAN_ID     = 8'h00,
    parameter int         ADDR_W      = 10,
    parameter int         PRE_SAMPLES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [7:0]        smp_data,
    input  logic              trig,
    input  logic [15:0]       trig_tag,
    input  logic [15:0]       post_len,
    input  logic              swap_req,
    output logic              mem_wr_en,
    output logic              mem_wr_bank,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [15:0]       mem_wr_data,
    output logic              active_bank,
    output logic              overflow,
    output logic              busy
);
    localparam int BANK_WORDS = 1 << ADDR_W;
    localparam int PRE_WORDS  = PRE_SAMPLES / 2;
    localparam int PAIR_W     = $clog2(PRE_WORDS);
    localparam int FIX_WORDS  = HDR_WORDS + PRE_WORDS;

    typedef struct packed {
        rec_state_e        state;
        logic              bank;
        logic [ADDR_W:0]   ptr;
        logic [ADDR_W-1:0] base;
        logic [15:0]       cnt;
        logic              half;
        logic [7:0]        hold;
        logic [15:0]       plen;
        logic [TS_W-1:0]   ts;
        logic [15:0]       tag;
        logic [15:0]       evn;
        logic              ovf;
        logic              swap_pend;
        logic              wr_en;
        logic              wr_bank;
        logic [ADDR_W-1:0] wr_addr;
        logic [15:0]       wr_data;
    } rec_regs_t;

    rec_regs_t         q, d;
    logic [TS_W-1:0]   ts_now;
    logic              hist_we;
    logic [7:0]        hist_lo;
    logic [7:0]        hist_hi;
    logic [PAIR_W-1:0] pair_idx;
    logic              bank_eff;
    logic [ADDR_W:0]   ptr_eff;
    logic [31:0]       need_words;
    logic              fits;
    logic [ADDR_W:0]   rec_words;

    wave_rec_tstamp #(.W(TS_W)) u_ts (
        .clk   (clk),
        .rst_n (rst_n),
        .ts    (ts_now)
    );

    wave_rec_history #(.DEPTH(PRE_SAMPLES), .SMP_W(8)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (hist_we),
        .wdat     (smp_data),
        .pair_idx (pair_idx),
        .rd_lo    (hist_lo),
        .rd_hi    (hist_hi)
    );

    assign pair_idx = q.cnt[PAIR_W-1:0];

    always_comb begin
        d          = q;
        d.wr_en    = 1'b0;
        hist_we    = 1'b0;
        bank_eff   = q.bank;
        ptr_eff    = q.ptr;
        need_words = 32'(FIX_WORDS) + 32'(post_len[15:1]);
        rec_words  = (ADDR_W+1)'(FIX_WORDS) + (ADDR_W+1)'(q.plen[15:1]);
        fits       = 1'b0;

        unique case (q.state)
            ST_IDLE: begin
                // A swap at a boundary is applied before any trigger in this cycle.
                if (q.swap_pend || swap_req) begin
                    bank_eff    = ~q.bank;
                    ptr_eff     = '0;
                    d.bank      = bank_eff;
                    d.ptr       = '0;
                    d.swap_pend = 1'b0;
                end
                fits = (32'(ptr_eff) + need_words) <= 32'(BANK_WORDS);
                if (trig && fits) begin
                    d.state = (post_len[15:1] == 15'd0) ? ST_PRE : ST_POST;
                    d.base  = ptr_eff[ADDR_W-1:0];
                    d.cnt   = '0;
                    d.plen  = post_len;
                    d.ts    = ts_now;
                    d.tag   = trig_tag;
                    d.half  = smp_valid && (post_len[15:1] != 15'd0);
                    d.hold  = smp_data;
                end else begin
                    if (trig) d.ovf = 1'b1;
                    hist_we = smp_valid;
                end
            end
            ST_POST: begin
                if (swap_req) d.swap_pend = 1'b1;
                if (smp_valid) begin
                    if (!q.half) begin
                        d.hold = smp_data;
                        d.half = 1'b1;
                    end else begin
                        d.half    = 1'b0;
                        d.wr_en   = 1'b1;
                        d.wr_bank = q.bank;
                        d.wr_addr = q.base + ADDR_W'(HDR_WORDS) + ADDR_W'(q.cnt);
                        d.wr_data = {smp_data, q.hold};
                        if (q.cnt + 16'd1 == {1'b0, q.plen[15:1]}) begin
                            d.state = ST_PRE;
                            d.cnt   = '0;
                        end else begin
                            d.cnt = q.cnt + 16'd1;
                        end
                    end
                end
            end
            ST_PRE: begin
                if (swap_req) d.swap_pend = 1'b1;
                d.wr_en   = 1'b1;
                d.wr_bank = q.bank;
                d.wr_addr = q.base + ADDR_W'(HDR_WORDS) + ADDR_W'(q.plen[15:1])
                          + ADDR_W'(q.cnt);
                d.wr_data = {hist_hi, hist_lo};
                if (q.cnt == 16'(PRE_WORDS - 1)) begin
                    d.state = ST_HDR;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 16'd1;
                end
            end
            ST_HDR: begin
                if (swap_req) d.swap_pend = 1'b1;
                d.wr_en   = 1'b1;
                d.wr_bank = q.bank;
                d.wr_addr = q.base + ADDR_W'(q.cnt);
                d.wr_data = hdr_word(q.cnt[2:0], CHAN_ID, q.plen, 16'(PRE_SAMPLES),
                                     q.evn, q.ts, q.tag);
                if (q.cnt == 16'(HDR_WORDS - 1)) begin
                    d.state = ST_IDLE;
                    d.cnt   = '0;
                    d.evn   = q.evn + 16'd1;
                    d.ptr   = {1'b0, q.base} + rec_words;
                end else begin
                    d.cnt = q.cnt + 16'd1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_wr_en   = q.wr_en;
    assign mem_wr_bank = q.wr_bank;
    assign mem_wr_addr = q.wr_addr;
    assign mem_wr_data = q.wr_data;
    assign active_bank = q.bank;
    assign overflow    = q.ovf;
    assign busy        = (q.state != ST_IDLE);
endmodule

// File: rtl/wave_rec_chk.sv
module wave_rec_chk (
    input logic clk,
    input logic rst_n,
    input logic trig,
    input logic busy,
    input logic mem_wr_en,
    input logic mem_wr_bank,
    input logic active_bank,
    input logic overflow
);
    // R12
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(trig));

    // R2
    wr_inside_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(busy));

    // R10
    swap_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_bank != $past(active_bank)) |-> !$past(busy));

    // R10
    wr_bank_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wr_bank == active_bank));

    // R11
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overflow) |-> overflow);
endmodule

bind wave_event_rec wave_rec_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig        (trig),
    .busy        (busy),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_bank (mem_wr_bank),
    .active_bank (active_bank),
    .overflow    (overflow)
);

// File: tb/wave_event_rec_tb.sv
`timescale 1ns/1ps
module wave_event_rec_tb;
    localparam int ADDR_W = 10;
    localparam int BANK   = 1 << ADDR_W;
    localparam logic [7:0] CHAN = 8'h5A;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [7:0]        smp_data = '0;
    logic              trig = 1'b0;
    logic [15:0]       trig_tag = '0;
    logic [15:0]       post_len = '0;
    logic              swap_req = 1'b0;
    logic              mem_wr_en;
    logic              mem_wr_bank;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [15:0]       mem_wr_data;
    logic              active_bank;
    logic              overflow;
    logic              busy;

    int checks = 0;
    int failures = 0;
    int wr_total = 0;
    logic [47:0] cyc = '0;

    logic [15:0] cap0 [BANK];
    logic [15:0] cap1 [BANK];
    logic [7:0]  hq   [128];
    logic [15:0] exp_w [BANK];
    logic [7:0]  ps   [4096];

    int   mptr = 0;
    bit   mbank = 1'b0;
    logic [15:0] mevn = '0;

    always #5 clk = ~clk;

    wave_event_rec #(.CHAN_ID(CHAN), .ADDR_W(ADDR_W), .PRE_SAMPLES(128)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .trig(trig), .trig_tag(trig_tag), .post_len(post_len), .swap_req(swap_req),
        .mem_wr_en(mem_wr_en), .mem_wr_bank(mem_wr_bank), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .active_bank(active_bank), .overflow(overflow),
        .busy(busy)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 1'b1;
    end

    always @(negedge clk) begin
        if (mem_wr_en) begin
            if (mem_wr_bank) cap1[mem_wr_addr] = mem_wr_data;
            else             cap0[mem_wr_addr] = mem_wr_data;
            wr_total++;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic void push_hist(input logic [7:0] v);
        for (int i = 0; i < 127; i++) hq[i] = hq[i+1];
        hq[127] = v;
    endfunction

    task automatic idle_samples(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            trig = 1'b0; swap_req = 1'b0;
            smp_valid = ($urandom % 4) != 0;
            smp_data  = 8'($urandom);
            if (smp_valid) push_hist(smp_data);
        end
    endtask

    task automatic swap_idle();
        @(negedge clk);
        smp_valid = 1'b0; trig = 1'b0; swap_req = 1'b1;
        mbank = ~mbank; mptr = 0;
        @(negedge clk);
        swap_req = 1'b0;
        chk(active_bank == mbank, "R10 idle swap bank", active_bank, mbank);
    endtask

    function automatic logic [15:0] rd_cap(input bit bk, input int a);
        return bk ? cap1[a] : cap0[a];
    endfunction

    task automatic do_record(input int post, input bit swap_busy, input bit swap_trig);
        int pw, total, got, wr0, base, iter, bad_h, bad_p, bad_r, fa;
        logic [15:0] fa_act, fa_exp;
        bit bk, ok, v;
        logic [7:0] d;
        logic [7:0] b [16];
        logic [47:0] ts;
        logic [15:0] tag;
        logic [15:0] w0, w1, w2, w3, w4, w5, w6;
        pw = post / 2;
        total = 8 + pw + 64;
        @(negedge clk);
        swap_req = 1'b0;
        if (swap_trig) begin mbank = ~mbank; mptr = 0; swap_req = 1'b1; end
        ok  = (mptr + total) <= BANK;
        v   = $urandom % 2;
        d   = 8'($urandom);
        tag = 16'($urandom);
        trig = 1'b1; trig_tag = tag; post_len = 16'(post);
        smp_valid = v; smp_data = d;
        ts = cyc;
        wr0 = wr_total;
        if (!ok) begin
            if (v) push_hist(d);
            @(negedge clk);
            trig = 1'b0; swap_req = 1'b0; smp_valid = 1'b0;
            repeat (3) @(negedge clk);
            chk(busy == 1'b0, "R11 dropped busy", busy, 0);
            chk(overflow == 1'b1, "R11 overflow set", overflow, 1);
            chk(wr_total == wr0, "R11 no writes", wr_total - wr0, 0);
            return;
        end
        base = mptr; bk = mbank;
        b[0] = CHAN; b[1] = post[15:8]; b[2] = post[7:0];
        b[3] = 8'h00; b[4] = 8'd128; b[5] = mevn[15:8]; b[6] = mevn[7:0];
        for (int i = 0; i < 6; i++) b[7+i] = ts[47-8*i -: 8];
        b[13] = tag[15:8]; b[14] = tag[7:0]; b[15] = 8'h00;
        for (int k = 0; k < 8; k++) exp_w[k] = {b[2*k+1], b[2*k]};
        for (int j = 0; j < 64; j++) exp_w[8+pw+j] = {hq[2*j+1], hq[2*j]};
        got = 0;
        if (v && pw > 0) begin ps[got] = d; got++; end
        iter = 0;
        forever begin
            @(negedge clk);
            if (iter == 0) chk(busy == 1'b1, "R12 busy after trigger", busy, 1);
            if (iter > 0 && !busy) begin
                trig = 1'b0; swap_req = 1'b0; smp_valid = 1'b0;
                break;
            end
            if (iter > 20000) begin
                chk(1'b0, "R12 record never finished", iter, 0);
                break;
            end
            swap_req  = (iter == 0) && swap_busy;
            trig      = ($urandom % 4) == 0;
            trig_tag  = 16'($urandom);
            smp_valid = $urandom % 2;
            smp_data  = 8'($urandom);
            if (smp_valid && got < 2*pw) begin ps[got] = smp_data; got++; end
            iter++;
        end
        for (int i = 0; i < pw; i++) exp_w[8+i] = {ps[2*i+1], ps[2*i]};
        @(negedge clk);
        chk(wr_total - wr0 == total, "R2/R9 write count", wr_total - wr0, total);
        bad_h = 0; bad_p = 0; bad_r = 0; fa = -1; fa_act = '0; fa_exp = '0;
        for (int i = 0; i < total; i++) begin
            if (rd_cap(bk, base + i) !== exp_w[i]) begin
                if (i < 8) bad_h++; else if (i < 8 + pw) bad_p++; else bad_r++;
                if (fa < 0) begin fa = i; fa_act = rd_cap(bk, base+i); fa_exp = exp_w[i]; end
            end
        end
        chk(bad_h == 0, "R3 header words", fa_act, fa_exp);
        chk(bad_p == 0, "R4 post words",   fa_act, fa_exp);
        chk(bad_r == 0, "R5 pre words",    fa_act, fa_exp);
        w0 = rd_cap(bk, base);   w1 = rd_cap(bk, base+1); w2 = rd_cap(bk, base+2);
        w3 = rd_cap(bk, base+3); w4 = rd_cap(bk, base+4); w5 = rd_cap(bk, base+5);
        w6 = rd_cap(bk, base+6);
        chk({w0[15:8], w1[7:0]} == 16'(post), "R6 post length field", {w0[15:8], w1[7:0]}, post);
        chk({w2[15:8], w3[7:0]} == mevn, "R7 event number", {w2[15:8], w3[7:0]}, mevn);
        chk({w3[15:8], w4[7:0], w4[15:8], w5[7:0], w5[15:8], w6[7:0]} == ts, "R8 timestamp",
            {w3[15:8], w4[7:0], w4[15:8], w5[7:0], w5[15:8], w6[7:0]}, ts);
        mevn = mevn + 16'd1;
        mptr = base + total;
        if (swap_busy) begin mbank = ~mbank; mptr = 0; end
        if (swap_busy || swap_trig)
            chk(active_bank == mbank, "R10 bank after swap", active_bank, mbank);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", checks);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240917);
        for (int i = 0; i < 128; i++) hq[i] = '0;
        for (int i = 0; i < BANK; i++) begin cap0[i] = '0; cap1[i] = '0; end
        repeat (4) @(negedge clk);
        chk(!mem_wr_en && !busy && !overflow && !active_bank, "R1 during reset",
            {mem_wr_en, busy, overflow, active_bank}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_wr_en && !busy && !overflow && !active_bank, "R1 after reset",
            {mem_wr_en, busy, overflow, active_bank}, 0);

        idle_samples(40);
        do_record(0, 1'b0, 1'b0);
        idle_samples(150);
        do_record(16, 1'b0, 1'b0);
        for (int n = 0; n < 4; n++) begin
            idle_samples(20 + int'($urandom % 180));
            do_record(2 * (int'($urandom % 30) + 1), 1'b0, 1'b0);
        end
        idle_samples(10);
        do_record(7, 1'b0, 1'b0);
        idle_samples(30);
        do_record(20, 1'b1, 1'b0);
        idle_samples(30);
        do_record(10, 1'b0, 1'b0);
        idle_samples(5);
        if (BANK - mptr - 72 >= 0) do_record(2 * (BANK - mptr - 72), 1'b0, 1'b0);
        idle_samples(5);
        do_record(4, 1'b0, 1'b0);
        swap_idle();
        chk(overflow == 1'b1, "R11 overflow sticky", overflow, 1);
        idle_samples(20);
        do_record(12, 1'b0, 1'b1);
        idle_samples(20);
        do_record(4000, 1'b0, 1'b0);
        idle_samples(20);
        do_record(6, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule